// File: doc/BRIEF.md
# ECC Error Address Capture Register

This block records where the first correctable (single-bit) ECC error was found in a vector table memory. A SECDED checker outside the block raises a one-cycle error strobe together with the byte offset of the failing entry from the table base. The block keeps the word-aligned form of that offset and raises a sticky error flag. From then on it ignores further single-bit errors until software clears the flag, so the first failing location is never overwritten by later ones.

Software reaches the block through a small register bus with read, write, word address, write data and a privilege qualifier. Reads are allowed in any mode. Writes take effect only when the privilege qualifier is high. The flag is cleared by writing one to its bit. The flag is reset, but the address storage has no reset at all, so a captured address survives every reset source. After power-up its contents are indeterminate, and they count as valid only while the flag is set. The error output line follows the flag, for use as an interrupt.

Top module: `ecc_fault_addr_capture`

## Requirements
- R1: An error strobe while the flag is clear sets the flag on the next clock edge and stores the strobed offset with its two low bits forced to zero. A privileged address write in the same cycle loses to the error.
- R2: While the flag is set, an error strobe with no flag-clear write in the same cycle leaves the stored address unchanged.
- R3: The two least significant bits of the stored address always read as zero (word alignment).
- R4: Reset drives the flag to 0 and leaves the stored address unchanged.
- R5: With bus_rd high, bus_rdata combinationally returns the stored address at word address 0 and the flag in bit 0 (other bits zero) at word address 1. It returns zero at any other word address and whenever bus_rd is low. Reads do not depend on bus_priv.
- R6: A privileged write to word address 0 stores the write data, with its two low bits zeroed, as the address on the next edge, provided no capture happens in that cycle.
- R7: A privileged write to word address 1 with data bit 0 set clears the flag on the next edge. With data bit 0 clear it has no effect.
- R8: A write with bus_priv low changes neither the flag nor the stored address.
- R9: An error strobe and a flag-clear write in the same cycle leave the flag set and capture the new offset (aligned).
- R10: err_irq equals the flag at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (flag only) |
| err_strobe | input | 1 | Single-bit error detected, one cycle |
| err_ofs | input | 32 | Byte offset of the failing entry from the table base |
| bus_rd | input | 1 | Register read enable |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_priv | input | 1 | High when the access is privileged |
| bus_rdata | output | 32 | Register read data |
| cap_addr | output | 32 | Stored error address |
| err_flag | output | 1 | Sticky error flag |
| err_irq | output | 1 | Error line to the interrupt controller |

## Verification
The embedded properties check on every cycle the capture on a clear flag, the hold of the address under a set flag, alignment while the flag is set, the survival of the flag when an error and a clear collide, and the inertness of unprivileged writes. The bench scenarios are needed for what spans a reset: the flag returns to zero while the address stays. They also cover the read decode at each word address and the rule that an error beats a privileged address write in the same cycle. The scoreboard compares each expected address and flag value against the ports after each operation.

// File: rtl/eccap_pkg.sv
package eccap_pkg;
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ADDR = 2'd1,
      SEL_FLAG = 2'd2
   } eccap_sel_e;
endpackage

// File: rtl/eccap_flag.sv
module eccap_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic err_strobe,
   input  logic clr_req,
   output logic cap_en,
   output logic flag
);
   // capture when flag clear, or when a clear collides with a new error
   assign cap_en = err_strobe && (!flag || clr_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag <= 1'b0;
      else if (err_strobe) flag <= 1'b1;
      else if (clr_req)    flag <= 1'b0;
   end

   // R9: error beats a simultaneous clear
   p_collide_keeps_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe && clr_req) |=> flag);

   // R7: clear without error drops the flag
   p_clear_drops_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !err_strobe) |=> !flag);
endmodule

// File: rtl/eccap_addr_store.sv
module eccap_addr_store #(
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [ADDR_W-1:0] err_ofs,
   input  logic              sw_we,
   input  logic [ADDR_W-1:0] sw_data,
   output logic [ADDR_W-1:0] addr_q
);
   localparam int ALIGN_LSB = $clog2(WORD_BYTES);

   logic [ADDR_W-1:0] err_al, sw_al;

   generate
      if (ALIGN_LSB > 0) begin : g_mask
         assign err_al = {err_ofs[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
         assign sw_al  = {sw_data[ADDR_W-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
      end else begin : g_nomask
         assign err_al = err_ofs;
         assign sw_al  = sw_data;
      end
   endgenerate

   // no reset on purpose: contents survive every reset source
   always_ff @(posedge clk) begin
      if (cap_en)     addr_q <= err_al;
      else if (sw_we) addr_q <= sw_al;
   end

   // R1: capture stores the aligned offset
   p_capture_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> (addr_q == $past(err_al)));

   // R6: software load when no capture
   p_sw_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_we && !cap_en) |=> (addr_q == $past(sw_al)));
endmodule

// File: rtl/eccap_regbus.sv
module eccap_regbus
   import eccap_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          DATA_W     = 32,
   parameter int          REG_AW     = 2,
   parameter int          FLAG_BIT   = 0,
   parameter logic [REG_AW-1:0] OFS_ADDR = '0,
   parameter logic [REG_AW-1:0] OFS_FLAG = 1
) (
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic              cur_flag,
   output logic              sw_addr_we,
   output logic              sw_flag_clr,
   output logic [DATA_W-1:0] bus_rdata
);
   eccap_sel_e sel;

   always_comb begin
      if (bus_addr == OFS_ADDR)      sel = SEL_ADDR;
      else if (bus_addr == OFS_FLAG) sel = SEL_FLAG;
      else                           sel = SEL_NONE;
   end

   assign sw_addr_we  = bus_wr && bus_priv && (sel == SEL_ADDR);
   assign sw_flag_clr = bus_wr && bus_priv && (sel == SEL_FLAG) && bus_wdata[FLAG_BIT];

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_ADDR: bus_rdata[ADDR_W-1:0] = cur_addr;
            SEL_FLAG: bus_rdata[FLAG_BIT]   = cur_flag;
            default:  bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ecc_fault_addr_capture.sv
module ecc_fault_addr_capture #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int REG_AW     = 2,
   parameter int WORD_BYTES = 4,
   parameter int FLAG_BIT   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_strobe,
   input  logic [ADDR_W-1:0] err_ofs,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_priv,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              err_flag,
   output logic              err_irq
);
   localparam int ALIGN_LSB = $clog2(WORD_BYTES);

   generate
      if (DATA_W < ADDR_W) begin : g_bad_width
         $error("DATA_W must be at least ADDR_W");
      end
      if (FLAG_BIT >= DATA_W) begin : g_bad_flag
         $error("FLAG_BIT outside the data word");
      end
      if ((1 << ALIGN_LSB) != WORD_BYTES) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (REG_AW < 1) begin : g_bad_aw
         $error("REG_AW must be at least 1");
      end
   endgenerate

   logic cap_en, sw_addr_we, sw_flag_clr;

   eccap_regbus #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .FLAG_BIT(FLAG_BIT),
      .OFS_ADDR(REG_AW'(0)), .OFS_FLAG(REG_AW'(1))
   ) u_bus (
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_priv(bus_priv),
      .cur_addr(cap_addr), .cur_flag(err_flag),
      .sw_addr_we(sw_addr_we), .sw_flag_clr(sw_flag_clr), .bus_rdata(bus_rdata)
   );

   eccap_flag u_flag (
      .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe),
      .clr_req(sw_flag_clr), .cap_en(cap_en), .flag(err_flag)
   );

   eccap_addr_store #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_store (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .err_ofs(err_ofs[ADDR_W-1:0]),
      .sw_we(sw_addr_we), .sw_data(bus_wdata[ADDR_W-1:0]), .addr_q(cap_addr)
   );

   assign err_irq = err_flag;

   // R2: address holds while flag set and nothing privileged touches it
   p_hold_while_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !sw_flag_clr && !sw_addr_we) |=> $stable(cap_addr));

   // R8: unprivileged write never clears the flag
   p_user_write_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_priv && err_flag) |=> err_flag);

   // R3: a valid address is word aligned
   p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> (cap_addr[ALIGN_LSB-1:0] == '0));

   // R1: strobe on a clear flag sets it
   p_strobe_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe && !err_flag) |=> err_flag);
endmodule

// File: tb/test_ecc_fault_addr_capture.sv
module test_ecc_fault_addr_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        err_strobe = 1'b0;
   logic [31:0] err_ofs = '0;
   logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata, cap_addr;
   logic        err_flag, err_irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      string       tag;
      bit          is_rd;
      bit          chk_a;
      logic [31:0] exp_a;
      logic        exp_f;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #10 clk = ~clk;  // 50 MHz

   ecc_fault_addr_capture i_ecc_fault_addr_capture (
      .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .err_ofs(err_ofs),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_priv(bus_priv), .bus_rdata(bus_rdata),
      .cap_addr(cap_addr), .err_flag(err_flag), .err_irq(err_irq)
   );

   // monitor: pop expectations and compare against the ports
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         begin
            sb_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (it.is_rd) begin
               if (bus_rdata !== it.exp_a) begin
                  errors++;
                  $display("FAIL %s rdata actual %h expected %h", it.tag, bus_rdata, it.exp_a);
               end
            end else begin
               if ((err_flag !== it.exp_f) || (err_irq !== it.exp_f) ||
                   (it.chk_a && (cap_addr !== it.exp_a))) begin
                  errors++;
                  $display("FAIL %s actual addr %h flag %b irq %b expected addr %h flag %b",
                           it.tag, cap_addr, err_flag, err_irq, it.exp_a, it.exp_f);
               end
            end
         end
      end
   end

   task automatic push(input string tag, input bit rd, input bit ca,
                       input logic [31:0] ea, input logic ef);
      sb_item_t it;
      it.tag = tag; it.is_rd = rd; it.chk_a = ca; it.exp_a = ea; it.exp_f = ef;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic step(input logic s, input logic [31:0] eo, input logic w,
                       input logic p, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      err_strobe = s; err_ofs = eo; bus_wr = w; bus_priv = p; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #2;
      err_strobe = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [1:0] a, input logic p,
                           input logic [31:0] exp);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a; bus_priv = p;
      #2;
      push(tag, 1'b1, 1'b0, exp, 1'b0);
      bus_rd = 1'b0; bus_priv = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      push("R4 R10 reset flag", 1'b0, 1'b0, '0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      step(1, 32'h0000_0123, 0, 0, 0, 0);
      push("R1 R3 first capture", 0, 1, 32'h0000_0120, 1'b1);
      rd_check("R5 user read addr", 2'd0, 1'b0, 32'h0000_0120);
      rd_check("R5 priv read flag", 2'd1, 1'b1, 32'h0000_0001);
      rd_check("R5 unmapped read", 2'd3, 1'b0, 32'h0);
      @(negedge clk); bus_addr = 2'd0; #2;
      push("R5 idle rdata", 1, 0, 32'h0, 1'b0);

      step(1, 32'h0000_0456, 0, 0, 0, 0);
      push("R2 later error ignored", 0, 1, 32'h0000_0120, 1'b1);
      step(0, 0, 1, 0, 2'd1, 32'h1);
      push("R8 user clear ignored", 0, 1, 32'h0000_0120, 1'b1);
      step(0, 0, 1, 0, 2'd0, 32'hFFFF_FFFF);
      push("R8 user addr write ignored", 0, 1, 32'h0000_0120, 1'b1);
      step(0, 0, 1, 1, 2'd1, 32'hFFFF_FFFE);
      push("R7 clear with bit0 low", 0, 1, 32'h0000_0120, 1'b1);
      step(0, 0, 1, 1, 2'd1, 32'h1);
      push("R7 R10 priv clear", 0, 1, 32'h0000_0120, 1'b0);

      step(1, 32'h0000_0008, 0, 0, 0, 0);
      push("R1 recapture", 0, 1, 32'h0000_0008, 1'b1);
      step(1, 32'h0000_0077, 1, 1, 2'd1, 32'h1);
      push("R9 error wins over clear", 0, 1, 32'h0000_0074, 1'b1);
      step(0, 0, 1, 1, 2'd0, 32'hDEAD_BEEF);
      push("R6 R3 priv addr write", 0, 1, 32'hDEAD_BEEC, 1'b1);

      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #2;
      push("R4 reset keeps addr", 0, 1, 32'hDEAD_BEEC, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      step(1, 32'h0000_0FF6, 1, 1, 2'd0, 32'h1234_5678);
      push("R1 error beats addr write", 0, 1, 32'h0000_0FF4, 1'b1);
      rd_check("R5 R3 read aligned", 2'd0, 1'b0, 32'h0000_0FF4);

      repeat (2) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule